// File: doc/BRIEF.md
# Light-Load Burst Mode Sequencer

This block sits beside the PWM core of a current-mode flyback controller. It decides when the converter stops switching on every cycle and moves into a low-power burst regime. In that regime it turns switching on and off in bursts, and it returns the converter to normal operation as soon as the load demands it. It sees the feedback node only through four digitised comparator flags:

- feedback below the entry level;
- feedback above the burst-start level;
- feedback below the burst-stop level;
- feedback above the exit level.

A millisecond tick paces the qualification timer.

Entry is slow and qualified. The feedback must sit below the entry level for a full, unbroken window of `ENTRY_MS` ticks. Inside burst mode, switching is gated by a hysteresis band: it starts at the upper level and stops at the lower one, and the peak current limit is held at the reduced setting. Exit is immediate. The first cycle that shows feedback above the exit level returns the block to normal mode with the full current limit, and no timer is involved. A synchronous reset or a controller-off input puts the block back in normal mode with the timer cleared.

Top module: `burst_ctrl`

## Requirements
- R1: While `rst` or `ctrl_off` is high at a clock edge, the block is in normal mode after that edge: `burst_mode`=0, `sw_en`=1, `ilim_low`=0. The entry timer is cleared, so a later entry needs a fresh full window.
- R2: In normal mode, the block enters burst mode on the clock edge that carries the `ENTRY_MS`-th `ms_tick`, provided `fb_below_enter` has been high in every cycle since the first of those ticks was counted.
- R3: Any cycle in normal mode with `fb_below_enter` low resets the entry count to zero.
- R4: On the edge that enters burst mode, `sw_en` goes to 0 and stays 0 until `fb_above_on` is seen.
- R5: In burst mode with switching off, an edge with `fb_above_on`=1 (and `fb_above_exit`=0) sets `sw_en`=1 after that edge, and the block remains in burst mode.
- R6: In burst mode with switching on, an edge with `fb_below_off`=1 (and `fb_above_exit`=0) sets `sw_en`=0 after that edge.
- R7: `ilim_low`=1 (reduced limit, 26% of full) exactly while `burst_mode`=1. In normal mode `ilim_low`=0, which selects the full limit.
- R8: In burst mode, an edge with `fb_above_exit`=1 returns the block to normal mode after that edge (`burst_mode`=0, `sw_en`=1, `ilim_low`=0). This exit takes priority over the start and stop flags.
- R9: In normal mode, `fb_above_on`, `fb_below_off` and `fb_above_exit` have no effect: `sw_en` stays 1 and no entry occurs because of them.
- R10: The entry count advances only on cycles where `ms_tick` and `fb_below_enter` are both high. Ticks with the flag low, or the flag high without ticks, never cause entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_off | input | 1 | Controller off; forces normal mode and clears the timer |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| fb_below_enter | input | 1 | Feedback below the burst entry level |
| fb_above_on | input | 1 | Feedback above the burst-start level |
| fb_below_off | input | 1 | Feedback below the burst-stop level |
| fb_above_exit | input | 1 | Feedback above the burst exit level |
| burst_mode | output | 1 | 1 while in burst mode |
| sw_en | output | 1 | Switching enable gate for the PWM |
| ilim_low | output | 1 | 1 selects the reduced current limit, 0 the full limit |

## Verification
The bench attacks the entry window from both sides:

- One tick short of the window must not enter burst mode. A design with an off-by-one counter would enter too early or one tick late.
- A single cycle of the entry flag dropping in the middle of the window must restart the count. A design that merely pauses would enter early.
- Millisecond ticks that arrive while the entry flag is low must not count.

It also drives the exit flag together with the start flag in burst mode. A design that gives the start flag priority would stay in burst mode with the reduced limit while the load collapses the output. Exit, start and stop flags are applied in normal mode to show that a design decoding them there would gate switching wrongly. Reset and controller-off are applied while in burst mode to confirm the full limit comes back.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL     = 2'd0,
        MODE_BURST_IDLE = 2'd1,
        MODE_BURST_RUN  = 2'd2
    } mode_e;

    typedef struct packed {
        logic below_enter;
        logic above_on;
        logic below_off;
        logic above_exit;
    } fb_flags_t;

    typedef struct packed {
        logic burst;
        logic sw_en;
        logic ilim_low;
    } ctl_out_t;

    // Next mode; exit beats start/stop, start/stop only act inside burst.
    function automatic mode_e mode_next(mode_e cur, fb_flags_t f, logic expire);
        mode_e nxt;
        nxt = cur;
        unique case (cur)
            MODE_NORMAL:     nxt = expire ? MODE_BURST_IDLE : MODE_NORMAL;
            MODE_BURST_IDLE: begin
                if (f.above_exit)    nxt = MODE_NORMAL;
                else if (f.above_on) nxt = MODE_BURST_RUN;
            end
            MODE_BURST_RUN:  begin
                if (f.above_exit)     nxt = MODE_NORMAL;
                else if (f.below_off) nxt = MODE_BURST_IDLE;
            end
            default:         nxt = MODE_NORMAL;
        endcase
        return nxt;
    endfunction

    function automatic ctl_out_t mode_decode(mode_e m);
        ctl_out_t o;
        o.burst    = (m != MODE_NORMAL);
        o.sw_en    = (m != MODE_BURST_IDLE);
        o.ilim_low = (m != MODE_NORMAL);
        return o;
    endfunction

endpackage

// File: rtl/burst_entry_timer.sv
module burst_entry_timer #(
    parameter int ENTRY_MS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic arm,
    input  logic tick,
    output logic expire
);
    localparam int CNT_W = (ENTRY_MS < 2) ? 1 : $clog2(ENTRY_MS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ENTRY_MS - 1);

    logic [CNT_W-1:0] cnt;
    logic             at_last;

    assign at_last = (cnt == LAST);
    assign expire  = arm && tick && at_last && !clear;

    always_ff @(posedge clk) begin
        if (rst || clear || !arm) begin
            cnt <= '0;
        end else if (tick) begin
            if (at_last) cnt <= '0;
            else         cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/burst_mode_fsm.sv
module burst_mode_fsm
    import burst_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ctrl_off,
    input  fb_flags_t flags,
    input  logic      expire,
    output mode_e     mode
);
    always_ff @(posedge clk) begin
        if (rst || ctrl_off) mode <= MODE_NORMAL;
        else                 mode <= mode_next(mode, flags, expire);
    end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_pkg::*;
#(
    parameter int ENTRY_MS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_off,
    input  logic ms_tick,
    input  logic fb_below_enter,
    input  logic fb_above_on,
    input  logic fb_below_off,
    input  logic fb_above_exit,
    output logic burst_mode,
    output logic sw_en,
    output logic ilim_low
);
    fb_flags_t flags;
    mode_e     mode;
    logic      expire;
    logic      tmr_clear;
    ctl_out_t  outs;

    assign flags = '{below_enter: fb_below_enter, above_on: fb_above_on,
                     below_off: fb_below_off, above_exit: fb_above_exit};

    // Timer only runs in normal mode with the controller on.
    assign tmr_clear = ctrl_off || (mode != MODE_NORMAL);

    burst_entry_timer #(.ENTRY_MS(ENTRY_MS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (tmr_clear),
        .arm    (fb_below_enter),
        .tick   (ms_tick),
        .expire (expire)
    );

    burst_mode_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ctrl_off (ctrl_off),
        .flags    (flags),
        .expire   (expire),
        .mode     (mode)
    );

    assign outs       = mode_decode(mode);
    assign burst_mode = outs.burst;
    assign sw_en      = outs.sw_en;
    assign ilim_low   = outs.ilim_low;
endmodule

// File: rtl/burst_ctrl_chk.sv
module burst_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic ctrl_off,
    input logic ms_tick,
    input logic fb_below_enter,
    input logic fb_above_on,
    input logic fb_below_off,
    input logic fb_above_exit,
    input logic burst_mode,
    input logic sw_en,
    input logic ilim_low
);
    // R1
    off_forces_normal_chk: assert property (@(posedge clk)
        (rst || ctrl_off) |=> (!burst_mode && sw_en && !ilim_low));

    // R2
    entry_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(burst_mode) |-> $past(fb_below_enter && ms_tick && !ctrl_off));

    // R4
    entry_sw_off_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(burst_mode) |-> !sw_en);

    // R5
    burst_start_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_mode && !sw_en && fb_above_on && !fb_above_exit && !ctrl_off)
        |=> (burst_mode && sw_en));

    // R6
    burst_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_mode && sw_en && fb_below_off && !fb_above_exit && !ctrl_off)
        |=> !sw_en);

    // R8
    fast_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_mode && fb_above_exit) |=> (!burst_mode && !ilim_low));

    // R9
    normal_switching_chk: assert property (@(posedge clk) disable iff (rst)
        !burst_mode |-> sw_en);
endmodule

bind burst_ctrl burst_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .ctrl_off       (ctrl_off),
    .ms_tick        (ms_tick),
    .fb_below_enter (fb_below_enter),
    .fb_above_on    (fb_above_on),
    .fb_below_off   (fb_below_off),
    .fb_above_exit  (fb_above_exit),
    .burst_mode     (burst_mode),
    .sw_en          (sw_en),
    .ilim_low       (ilim_low)
);

// File: tb/tb_burst_ctrl.sv
module tb_burst_ctrl;
    localparam int E = 6;

    logic clk = 1'b0;
    logic rst, ctrl_off, ms_tick, lo, on, off, ex;
    logic burst_mode, sw_en, ilim_low;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // model: 0 normal, 1 burst idle, 2 burst run
    int m_mode = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    burst_ctrl #(.ENTRY_MS(E)) dut (
        .clk(clk), .rst(rst), .ctrl_off(ctrl_off), .ms_tick(ms_tick),
        .fb_below_enter(lo), .fb_above_on(on), .fb_below_off(off),
        .fb_above_exit(ex), .burst_mode(burst_mode), .sw_en(sw_en),
        .ilim_low(ilim_low)
    );

    function automatic void model_edge(bit r, bit co, bit l, bit tk, bit o_on, bit o_off, bit o_ex);
        if (r || co) begin
            m_mode = 0; m_cnt = 0;
        end else begin
            case (m_mode)
                0: begin
                    if (!l) m_cnt = 0;
                    else if (tk) begin
                        if (m_cnt == E - 1) begin m_mode = 1; m_cnt = 0; end
                        else m_cnt = m_cnt + 1;
                    end
                end
                1: begin m_cnt = 0; if (o_ex) m_mode = 0; else if (o_on) m_mode = 2; end
                default: begin m_cnt = 0; if (o_ex) m_mode = 0; else if (o_off) m_mode = 1; end
            endcase
        end
    endfunction

    task automatic chk(string tag, string what, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic step(bit r, bit co, bit l, bit tk, bit o_on, bit o_off, bit o_ex, string tag);
        @(negedge clk);
        rst = r; ctrl_off = co; lo = l; ms_tick = tk; on = o_on; off = o_off; ex = o_ex;
        @(posedge clk);
        model_edge(r, co, l, tk, o_on, o_off, o_ex);
        #1;
        chk(tag, "burst_mode", burst_mode, m_mode != 0);
        chk(tag, "sw_en", sw_en, m_mode != 1);
        chk(tag, "ilim_low", ilim_low, m_mode != 0);
    endtask

    task automatic enter_burst();
        for (int i = 0; i < E; i++) step(0, 0, 1, 1, 0, 0, 0, "R2");
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd4711);
        rst = 1; ctrl_off = 0; ms_tick = 0; lo = 0; on = 0; off = 0; ex = 0;
        step(1, 0, 0, 0, 0, 0, 0, "R1");
        step(1, 0, 1, 1, 1, 1, 1, "R1");

        // R2: one tick short stays normal, the E-th tick enters
        for (int i = 0; i < E - 1; i++) step(0, 0, 1, 1, 0, 0, 0, "R2");
        chk("R2", "no early entry", burst_mode, 1'b0);
        step(0, 0, 1, 1, 0, 0, 0, "R2");
        chk("R2", "entered", burst_mode, 1'b1);
        chk("R4", "switching off on entry", sw_en, 1'b0);
        step(0, 0, 1, 0, 0, 1, 0, "R4");
        chk("R4", "still off", sw_en, 1'b0);
        // R5 / R7
        step(0, 0, 0, 0, 1, 0, 0, "R5");
        chk("R5", "start", sw_en, 1'b1);
        chk("R7", "reduced limit", ilim_low, 1'b1);
        // R6
        step(0, 0, 0, 0, 0, 1, 0, "R6");
        chk("R6", "stop", sw_en, 1'b0);
        // R8: exit beats start
        step(0, 0, 0, 0, 1, 0, 1, "R8");
        chk("R8", "exit", burst_mode, 1'b0);
        chk("R8", "full limit", ilim_low, 1'b0);
        // R8 from running state
        enter_burst();
        step(0, 0, 0, 0, 1, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 1, 1, "R8");
        chk("R8", "exit from run", burst_mode, 1'b0);

        // R3: interruption restarts the window
        for (int i = 0; i < E - 2; i++) step(0, 0, 1, 1, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, 0, "R3");
        for (int i = 0; i < E - 1; i++) step(0, 0, 1, 1, 0, 0, 0, "R3");
        chk("R3", "restarted count", burst_mode, 1'b0);
        step(0, 0, 1, 1, 0, 0, 0, "R3");
        chk("R3", "entered after fresh window", burst_mode, 1'b1);

        // R1: controller-off in burst, then fresh window needed
        step(0, 1, 1, 1, 1, 0, 0, "R1");
        chk("R1", "off clears burst", burst_mode, 1'b0);
        for (int i = 0; i < E - 1; i++) step(0, 0, 1, 1, 0, 0, 0, "R1");
        chk("R1", "timer cleared", burst_mode, 1'b0);
        step(0, 1, 0, 0, 0, 0, 0, "R1");

        // R10: flag without ticks, ticks without flag
        for (int i = 0; i < 3 * E; i++) step(0, 0, 1, 0, 0, 0, 0, "R10");
        for (int i = 0; i < 3 * E; i++) step(0, 0, 0, 1, 0, 0, 0, "R10");
        chk("R10", "no entry", burst_mode, 1'b0);

        // R9: burst flags ignored in normal mode
        step(0, 0, 0, 1, 0, 1, 0, "R9");
        chk("R9", "stop flag ignored", sw_en, 1'b1);
        step(0, 0, 0, 1, 1, 0, 1, "R9");
        chk("R9", "exit flag ignored", sw_en, 1'b1);

        // reset inside burst
        enter_burst();
        step(1, 0, 1, 1, 1, 0, 0, "R1");
        chk("R1", "reset clears burst", ilim_low, 1'b0);

        // constrained random
        begin
            bit l = 0;
            for (int i = 0; i < 4000; i++) begin
                bit tk, o_on, o_off, o_ex, co;
                if ($urandom % 12 == 0) l = ~l;
                tk    = ($urandom % 2) == 0;
                o_on  = ($urandom % 4) == 0;
                o_off = ($urandom % 4) == 0;
                o_ex  = ($urandom % 25) == 0;
                co    = ($urandom % 150) == 0;
                step(0, co, l, tk, o_on, o_off, o_ex, "R7");
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule